// File: doc/BRIEF.md
# Converter Power-Up Synchronization Sequencer

This block sequences the start of conversion for the digital back end of a stereo oversampling ADC. It watches two active-low power-down pins. One belongs to the digital filters and clock generators, the other to the analog modulators. When the digital pin is released, the block enables the filter clocks. It then waits until it has aligned itself to the serial clocks, and only then declares conversion running. In slave mode it aligns to the external bit clock and frame clock. In master mode it aligns to an internally supplied frame clock.

Once running, the block emits one strobe on every frame-clock rising edge. It holds the data-valid flag low for two windows. The first is a fixed number of frames that covers the group delay of the decimation and high-pass filters. The second is a settling time after analog release, counted in system-clock cycles. A drop of either power-down pin clears the valid flag at once. A drop of the digital pin also restarts the whole sequence.

The power-down pins and the mode select are assumed to be synchronous to `clk`. The three serial clocks are asynchronous and pass through two-flop synchronizers inside the block.

Top module: `adc_pwrup_seq`

## Requirements
- R1: `filt_en` is low in the cycle after any clock edge that samples `dig_pd_n` low. After reset and after each release, it goes high in the cycle after the first edge that samples `dig_pd_n` high.
- R2: In slave mode (`master_sel`=0), `running` rises only after a rising edge of `bclk_in` and a rising edge of `fclk_in` have both been detected after release, in either order. An input change is detected at the second `clk` edge that samples it. `running` rises in the cycle after the edge that completes the pair.
- R3: In master mode (`master_sel`=1), `running` rises in the cycle after the first detected rising edge of `int_fclk` following release. `bclk_in` and `fclk_in` are ignored.
- R4: While `running` is high, `conv_stb` is a one-cycle pulse for each detected rising edge of the selected frame clock. This is `int_fclk` in master mode and `fclk_in` in slave mode. `conv_stb` is never high while `running` is low.
- R5: `data_valid` stays low until GRP_FRAMES (default 26) strobes have been issued since the last release of `dig_pd_n`.
- R6: `data_valid` stays low until `ana_pd_n` has been sampled high on SETTLE_CYC consecutive clock edges. SETTLE_CYC = SETTLE_US × SYS_CLK_KHZ / 1000, which is 100 ms by default.
- R7: `data_valid` is low in any cycle in which `dig_pd_n` or `ana_pd_n` is low, with no clock delay.
- R8: Sampling `dig_pd_n` low clears `running`, the synchronization state and both window counters. The next release repeats the full sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_pd_n | input | 1 | Digital power-down, low = filters and clock generators off |
| ana_pd_n | input | 1 | Analog power-down, low = modulators off |
| master_sel | input | 1 | 1 = master (internal frame clock), 0 = slave (external clocks) |
| bclk_in | input | 1 | External serial bit clock, asynchronous |
| fclk_in | input | 1 | External left/right frame clock, asynchronous |
| int_fclk | input | 1 | Internally generated frame clock for master mode, asynchronous |
| filt_en | output | 1 | Filter and clock-generator enable |
| running | output | 1 | Conversion synchronized and running |
| conv_stb | output | 1 | One-cycle strobe per frame while running |
| data_valid | output | 1 | Filter output data may be used |

## Verification
The assertions assume that `master_sel` stays constant while `dig_pd_n` is high. They also assume that every serial clock holds each level for at least two system-clock cycles, so each rising edge yields exactly one detect pulse. The bench changes the mode only while the digital pin is held low. It generates the serial clocks as slow divided waveforms, with half periods of 4 and 32 system cycles, driven on the falling system-clock edge. The bench also stops and restarts single clocks, so that both edge orders and the restart after a digital drop are covered.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_ARM  = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int W = STAGES + 1;

  logic [W-1:0] sh_q, sh_n;

  always_comb begin
    sh_n = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/win_counter.sv
module win_counter #(
  parameter int LIMIT = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                     cnt_n = '0;
    else if (inc && cnt_q != TOP) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign done = (cnt_q == TOP);

  // R5, R6
  win_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(clr));

  // R5, R6
  win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(inc));

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dig_pd_n,
  input  logic master_sel,
  input  logic bclk_rise,
  input  logic ext_frm_rise,
  input  logic int_frm_rise,
  output logic filt_en,
  output logic running,
  output logic frm_rise
);

  phase_t st_q, st_n;
  logic   seen_b_q, seen_b_n;
  logic   seen_f_q, seen_f_n;
  logic   b_ok, f_ok;

  always_comb begin
    st_n     = st_q;
    seen_b_n = seen_b_q;
    seen_f_n = seen_f_q;
    b_ok     = seen_b_q | bclk_rise;
    f_ok     = seen_f_q | ext_frm_rise;
    unique case (st_q)
      PH_DOWN: begin
        seen_b_n = 1'b0;
        seen_f_n = 1'b0;
        if (dig_pd_n) st_n = PH_ARM;
      end
      PH_ARM: begin
        if (master_sel) begin
          if (int_frm_rise) st_n = PH_RUN;
        end else begin
          seen_b_n = b_ok;
          seen_f_n = f_ok;
          if (b_ok && f_ok) st_n = PH_RUN;
        end
      end
      PH_RUN:  st_n = PH_RUN;
      default: st_n = PH_DOWN;
    endcase
    if (!dig_pd_n) begin
      st_n     = PH_DOWN;
      seen_b_n = 1'b0;
      seen_f_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_DOWN;
      seen_b_q <= 1'b0;
      seen_f_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      seen_b_q <= seen_b_n;
      seen_f_q <= seen_f_n;
    end
  end

  assign filt_en  = (st_q != PH_DOWN);
  assign running  = (st_q == PH_RUN);
  assign frm_rise = master_sel ? int_frm_rise : ext_frm_rise;

  // R1
  filt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_pd_n |=> !filt_en);

  // R8
  run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_pd_n |=> !running);

  // R3
  master_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && master_sel) |-> $past(int_frm_rise));

  // R2
  slave_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && !master_sel) |-> $past(filt_en));

endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq #(
  parameter int SYS_CLK_KHZ = 50000,
  parameter int SETTLE_US   = 100000,
  parameter int GRP_FRAMES  = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dig_pd_n,
  input  logic ana_pd_n,
  input  logic master_sel,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic int_fclk,
  output logic filt_en,
  output logic running,
  output logic conv_stb,
  output logic data_valid
);

  localparam int SETTLE_CYC = SETTLE_US * (SYS_CLK_KHZ / 1000);
  localparam int N_CLK      = 3;

  logic [N_CLK-1:0] raw_clk, raw_rise;
  logic             frm_rise, grp_done, settle_done;

  assign raw_clk = {int_fclk, fclk_in, bclk_in};

  for (genvar g = 0; g < N_CLK; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_es (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_clk[g]),
      .rise (raw_rise[g])
    );
  end

  sync_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dig_pd_n    (dig_pd_n),
    .master_sel  (master_sel),
    .bclk_rise   (raw_rise[0]),
    .ext_frm_rise(raw_rise[1]),
    .int_frm_rise(raw_rise[2]),
    .filt_en     (filt_en),
    .running     (running),
    .frm_rise    (frm_rise)
  );

  assign conv_stb = running & frm_rise;

  win_counter #(.LIMIT(GRP_FRAMES)) u_grp (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!dig_pd_n),
    .inc  (conv_stb),
    .done (grp_done)
  );

  win_counter #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!dig_pd_n || !ana_pd_n),
    .inc  (1'b1),
    .done (settle_done)
  );

  assign data_valid = running & grp_done & settle_done & dig_pd_n & ana_pd_n;

  // R4
  stb_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stb |-> running);

  // R5
  valid_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(dig_pd_n));

endmodule

// File: tb/tb_adc_pwrup_seq.sv
module tb_adc_pwrup_seq;

  localparam int KHZ  = 50000;
  localparam int SUS  = 10;
  localparam int GRP  = 26;
  localparam int SCYC = SUS * (KHZ / 1000);
  localparam int BH   = 4;
  localparam int FH   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dig_pd_n = 1'b0, ana_pd_n = 1'b0, master_sel = 1'b0;
  logic bclk_in = 1'b0, fclk_in = 1'b0, int_fclk = 1'b0;
  logic filt_en, running, conv_stb, data_valid;

  int checks = 0, failures = 0;
  bit run_b = 0, run_f = 0, run_i = 0;
  int cb = 0, cf = 0, ci = 0;
  int stb_seen = 0;

  adc_pwrup_seq #(.SYS_CLK_KHZ(KHZ), .SETTLE_US(SUS), .GRP_FRAMES(GRP)) dut (
    .clk(clk), .rst_n(rst_n), .dig_pd_n(dig_pd_n), .ana_pd_n(ana_pd_n),
    .master_sel(master_sel), .bclk_in(bclk_in), .fclk_in(fclk_in),
    .int_fclk(int_fclk), .filt_en(filt_en), .running(running),
    .conv_stb(conv_stb), .data_valid(data_valid)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (run_b) begin cb++; if (cb % BH == 0) bclk_in <= ~bclk_in; end
    if (run_f) begin cf++; if (cf % FH == 0) fclk_in <= ~fclk_in; end
    if (run_i) begin ci++; if (ci % FH == 0) int_fclk <= ~int_fclk; end
  end

  // reference model: sample history per serial clock, phase, counts
  int hb[$] = '{0, 0, 0};
  int hf[$] = '{0, 0, 0};
  int hi[$] = '{0, 0, 0};
  int ph = 0, sb = 0, sf = 0, frames = 0, settle = 0;
  bit model_on = 0;

  function automatic bit rose_of(int h[$]);
    return (h[1] == 1) && (h[2] == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb = '{0, 0, 0}; hf = '{0, 0, 0}; hi = '{0, 0, 0};
      ph = 0; sb = 0; sf = 0; frames = 0; settle = 0;
    end else begin
      bit rb, rf, ri, fr;
      rb = rose_of(hb); rf = rose_of(hf); ri = rose_of(hi);
      fr = master_sel ? ri : rf;
      if (!dig_pd_n) frames = 0;
      else if (ph == 2 && fr && frames < GRP) frames++;
      if (!dig_pd_n || !ana_pd_n) settle = 0;
      else if (settle < SCYC) settle++;
      if (!dig_pd_n) begin ph = 0; sb = 0; sf = 0; end
      else if (ph == 0) begin ph = 1; sb = 0; sf = 0; end
      else if (ph == 1) begin
        if (master_sel) begin if (ri) ph = 2; end
        else begin
          if (rb) sb = 1;
          if (rf) sf = 1;
          if (sb && sf) ph = 2;
        end
      end
      hb.push_front(int'(bclk_in)); void'(hb.pop_back());
      hf.push_front(int'(fclk_in)); void'(hf.pop_back());
      hi.push_front(int'(int_fclk)); void'(hi.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #15;
    if (model_on) begin
      bit e_run, e_stb, e_val;
      e_run = (ph == 2);
      e_stb = e_run && (master_sel ? rose_of(hi) : rose_of(hf));
      e_val = e_run && frames == GRP && settle == SCYC && dig_pd_n && ana_pd_n;
      chk(filt_en === (ph != 0), "R1 filt_en", int'(filt_en), int'(ph != 0));
      chk(running === e_run, "R2/R3 running", int'(running), int'(e_run));
      chk(conv_stb === e_stb, "R4 conv_stb", int'(conv_stb), int'(e_stb));
      chk(data_valid === e_val, "R5/R6/R7 data_valid", int'(data_valid), int'(e_val));
      if (conv_stb) stb_seen++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    model_on = 1;
    wait_cyc(2);
    chk(!filt_en && !running && !data_valid && !conv_stb, "R1 reset state",
        int'({filt_en, running, data_valid}), 0);

    // slave, bit clock first, frame clock held still
    run_b = 1; ana_pd_n = 1'b1; dig_pd_n = 1'b1;
    wait_cyc(2);
    chk(filt_en === 1'b1, "R1 enable after release", int'(filt_en), 1);
    wait_cyc(300);
    chk(running === 1'b0, "R2 no start without frame edge", int'(running), 0);
    run_f = 1;
    wait_cyc(2200);
    chk(data_valid === 1'b1, "R5 R6 valid after windows", int'(data_valid), 1);

    // analog drop clears at once, then settling is counted again
    ana_pd_n = 1'b0;
    #1 chk(data_valid === 1'b0, "R7 valid drops with analog pin", int'(data_valid), 0);
    wait_cyc(1);
    ana_pd_n = 1'b1;
    wait_cyc(SCYC - 20);
    chk(data_valid === 1'b0, "R6 still settling", int'(data_valid), 0);
    chk(running === 1'b1, "R6 analog drop keeps sync", int'(running), 1);
    wait_cyc(40);
    chk(data_valid === 1'b1, "R6 valid after settling", int'(data_valid), 1);

    // digital drop restarts; this time frame clock runs first
    dig_pd_n = 1'b0;
    #1 chk(data_valid === 1'b0, "R7 valid drops with digital pin", int'(data_valid), 0);
    wait_cyc(3);
    chk(!running && !filt_en, "R8 sync cleared", int'({running, filt_en}), 0);
    run_b = 0;
    wait_cyc(5);
    dig_pd_n = 1'b1;
    wait_cyc(300);
    chk(running === 1'b0, "R2 no start without bit edge", int'(running), 0);
    run_b = 1;
    wait_cyc(20);
    chk(running === 1'b1, "R2 start on bit edge after frame edge", int'(running), 1);
    wait_cyc(1000);
    chk(data_valid === 1'b0, "R8 group window restarted", int'(data_valid), 0);
    wait_cyc(800);
    chk(data_valid === 1'b1, "R5 valid after 26 new frames", int'(data_valid), 1);

    // master mode: external clocks stopped, internal frame clock used
    dig_pd_n = 1'b0;
    wait_cyc(3);
    run_b = 0; run_f = 0;
    master_sel = 1'b1; run_i = 1;
    wait_cyc(5);
    dig_pd_n = 1'b1;
    wait_cyc(100);
    chk(running === 1'b1, "R3 master start on internal frame", int'(running), 1);
    stb_seen = 0;
    wait_cyc(640);
    chk(stb_seen == 10, "R4 one strobe per frame", stb_seen, 10);
    wait_cyc(2000);
    chk(data_valid === 1'b1, "R5 master valid", int'(data_valid), 1);

    finish_run();
  end

endmodule